// File: doc/BRIEF.md
# Monochrome OLED Panel Bring-Up Sequencer

This block brings a monochrome OLED panel controller out of reset and into a running state. When `start_i` is pulsed, it can first drive a reset pulse to the panel. It then emits a fixed, ordered stream of command bytes with their option bytes, and ends with the display-on command. A downstream SPI or I2C serializer consumes the stream through a valid/ready handshake. Each byte is qualified by a data/command flag, and every byte of this sequence is a command.

Option bytes are assembled from configuration inputs by packing flags and small fields into fixed bit positions. Two steps depend on configuration and may be absent from the stream: the area-colour/low-power step and the gamma lookup-table step. A sticky warning flag reports lookup-table entries outside the usable range. The configuration inputs must be held stable from the start pulse until `done_o` rises.

Top module: `oled_init_seq`

## Requirements
- R1: After synchronous reset, `panel_rst_o`, `tx_valid_o`, `done_o`, `busy_o` and `lut_warn_o` are all 0.
- R2: When `rst_ctl_en_i` is 1 at start, the sequence runs in three phases with no byte offered during the first two.
  - `panel_rst_o` is high for exactly RST_US microseconds of clock cycles (200 cycles at the default 50 MHz and 4 µs).
  - It is then low for the same count.
  - The first byte is offered only after that.
  - When `rst_ctl_en_i` is 0, the first byte is offered in the cycle after the start pulse and `panel_rst_o` stays 0.
- R3: The bytes appear in this order:
  - 0x81 followed by the contrast value.
  - The segment-remap byte, then the scan-direction byte.
  - 0xA8 followed by its option, then 0xD3 followed by the row offset, then 0xD5 followed by its option.
  - The optional area step.
  - 0xD9 followed by its option, 0xDA followed by its option, 0xDB followed by the VCOMH level, 0x8D followed by its option.
  - The optional lookup-table step.
  - 0x20 followed by its option, and finally 0xAF.
  - `tx_dc_o` is 0 for every byte.
- R4: The following bytes are built from configuration fields:
  - Segment remap is 0xA0 with the remap flag in bit 0.
  - Scan direction is 0xC0 with the invert flag in bit 3.
  - The 0xA8 option is the row count minus one.
  - The 0xD5 option carries (divider − 1) in bits 3:0 and the oscillator code in bits 7:4.
  - The 0xD9 option carries phase 1 in bits 3:0 and phase 2 in bits 7:4.
- R5: The area step, 0xD8 followed by its option, is present only when area colour or low power is enabled. Its option is the OR of 0x1E (area colour) and 0x05 (low power).
- R6: Two option bytes have fixed base bits plus flag bits:
  - The 0xDA option is 0x02, plus bit 4 set when sequential COM is off, plus bit 5 equal to the left/right swap flag.
  - The 0x8D option is 0x10, plus bit 2 when the internal pump is needed.
- R7: When the table is enabled, 0x91 is sent followed by LUT_N entries, entry 0 first, where entry i is `lut_i[8*i+7:8*i]`. When the table is disabled, none of these bytes appear.
- R8: `lut_warn_o` is set when a table entry below 31 or above 63 is accepted. It stays set until the next accepted start.
- R9: The 0x20 option is 0x02 in page mode and 0x00 otherwise. `done_o` rises the cycle after 0xAF is accepted, with `tx_valid_o` low, and holds until the next start.
- R10: A byte advances only on `tx_valid_o && tx_ready_i`. While valid is high and ready is low, the byte is held unchanged.
- R11: `start_i` is ignored while `busy_o` is high. A start from the done state reruns the whole sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse |
| rst_ctl_en_i | input | 1 | A panel reset line is present; pulse it before commands |
| contrast_i | input | 8 | Contrast level |
| seg_remap_i | input | 1 | Segment remap flag |
| scan_inv_i | input | 1 | Invert COM scan direction |
| rows_i | input | 8 | Panel row count |
| row_offset_i | input | 8 | Display row offset |
| clk_div_i | input | 5 | Display clock divider, 1..16 |
| osc_code_i | input | 4 | Oscillator frequency code |
| area_col_i | input | 1 | Enable area colour |
| low_pwr_i | input | 1 | Enable low-power mode |
| pre_ph1_i | input | 4 | Precharge phase 1 length |
| pre_ph2_i | input | 4 | Precharge phase 2 length |
| com_seq_i | input | 1 | Sequential COM pin layout |
| com_swap_i | input | 1 | COM left/right swap |
| vcomh_i | input | 8 | VCOMH deselect level |
| pump_i | input | 1 | Panel needs internal charge pump |
| lut_en_i | input | 1 | Send gamma lookup table |
| lut_i | input | 8*LUT_N | Lookup-table entries, entry 0 in low byte |
| page_mode_i | input | 1 | Select page addressing |
| tx_data_o | output | 8 | Byte to serializer |
| tx_dc_o | output | 1 | Data/command flag (0 = command) |
| tx_valid_o | output | 1 | Byte valid |
| tx_ready_i | input | 1 | Serializer accepts byte |
| panel_rst_o | output | 1 | Active-high panel reset |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished |
| lut_warn_o | output | 1 | Out-of-range table entry seen |

## Verification
The bound checker watches several properties on every cycle:
- The held byte under backpressure stays unchanged.
- The panel reset and the byte stream never overlap.
- `done_o` rises only after 0xAF is taken.
- The warning flag rises only on a handshake.
- Start pulses are ignored while a run is in progress.

The exact order, the field packing of each option byte, the presence or absence of the optional steps, and the reset phase lengths can be shown only by the bench. Its reference model builds the expected byte list from the configuration and compares the outputs on every clock, over runs with different configurations and ready patterns.

// File: rtl/oled_init_pkg.sv
package oled_init_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST_HI,
    ST_RST_LO,
    ST_SEND,
    ST_DONE
  } seq_state_e;

  typedef struct packed {
    logic [7:0] contrast;
    logic       seg_remap;
    logic       scan_inv;
    logic [7:0] rows;
    logic [7:0] row_offset;
    logic [4:0] clk_div;
    logic [3:0] osc_code;
    logic       area_col;
    logic       low_pwr;
    logic [3:0] pre_ph1;
    logic [3:0] pre_ph2;
    logic       com_seq;
    logic       com_swap;
    logic [7:0] vcomh;
    logic       pump;
    logic       lut_en;
    logic       page_mode;
  } panel_cfg_t;

  localparam logic [7:0] OP_CONTRAST = 8'h81;
  localparam logic [7:0] OP_SEGMAP   = 8'hA0;
  localparam logic [7:0] OP_SCANDIR  = 8'hC0;
  localparam logic [7:0] OP_MUX      = 8'hA8;
  localparam logic [7:0] OP_OFFSET   = 8'hD3;
  localparam logic [7:0] OP_CLOCK    = 8'hD5;
  localparam logic [7:0] OP_AREA     = 8'hD8;
  localparam logic [7:0] OP_PRECH    = 8'hD9;
  localparam logic [7:0] OP_COMPINS  = 8'hDA;
  localparam logic [7:0] OP_VCOMH    = 8'hDB;
  localparam logic [7:0] OP_PUMP     = 8'h8D;
  localparam logic [7:0] OP_GAMMA    = 8'h91;
  localparam logic [7:0] OP_ADDRMODE = 8'h20;
  localparam logic [7:0] OP_ON       = 8'hAF;

  localparam int LUT_LO = 31;
  localparam int LUT_HI = 63;

  // Slot numbering of the fixed part of the stream
  localparam int SLOT_AREA  = 10;
  localparam int SLOT_PRE   = 12;
  localparam int SLOT_GAMMA = 20;
  localparam int SLOT_LUT0  = 21;

  function automatic logic lut_bad(input logic [7:0] v);
    return (int'(v) < LUT_LO) || (int'(v) > LUT_HI);
  endfunction

endpackage

// File: rtl/oled_delay_cnt.sv
module oled_delay_cnt #(
  parameter int CYC = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  output logic expired
);
  localparam int CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt_q;

  assign expired = (cnt_q == CW'(CYC - 1));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (!expired) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/oled_slot_seq.sv
module oled_slot_seq #(
  parameter int LUT_N = 4,
  localparam int NSLOT = oled_init_pkg::SLOT_LUT0 + LUT_N + 3,
  localparam int SW = $clog2(NSLOT)
) (
  input  logic [SW-1:0] slot_i,
  input  logic          area_any_i,
  input  logic          lut_en_i,
  output logic [SW-1:0] next_o,
  output logic          last_o,
  output logic          is_lut_o
);
  import oled_init_pkg::*;

  localparam int SLOT_ADDR = SLOT_LUT0 + LUT_N;
  localparam int SLOT_LAST = SLOT_ADDR + 2;

  int s;
  int n;

  always_comb begin
    s = int'(slot_i);
    n = s + 1;
    if (n == SLOT_AREA && !area_any_i) n = SLOT_PRE;
    if (n == SLOT_GAMMA && !lut_en_i)  n = SLOT_ADDR;
    next_o   = SW'(n);
    last_o   = (s == SLOT_LAST);
    is_lut_o = (s >= SLOT_LUT0) && (s < SLOT_ADDR);
  end
endmodule

// File: rtl/oled_byte_gen.sv
module oled_byte_gen #(
  parameter int LUT_N = 4,
  localparam int NSLOT = oled_init_pkg::SLOT_LUT0 + LUT_N + 3,
  localparam int SW = $clog2(NSLOT)
) (
  input  logic [SW-1:0]          slot_i,
  input  oled_init_pkg::panel_cfg_t cfg_i,
  input  logic [8*LUT_N-1:0]     lut_i,
  output logic [7:0]             byte_o
);
  import oled_init_pkg::*;

  localparam int SLOT_ADDR = SLOT_LUT0 + LUT_N;

  int s;

  always_comb begin
    s = int'(slot_i);
    byte_o = 8'h00;
    case (s)
      0:  byte_o = OP_CONTRAST;
      1:  byte_o = cfg_i.contrast;
      2:  byte_o = OP_SEGMAP | {7'b0, cfg_i.seg_remap};
      3:  byte_o = OP_SCANDIR | {4'b0, cfg_i.scan_inv, 3'b0};
      4:  byte_o = OP_MUX;
      5:  byte_o = cfg_i.rows - 8'd1;
      6:  byte_o = OP_OFFSET;
      7:  byte_o = cfg_i.row_offset;
      8:  byte_o = OP_CLOCK;
      9:  byte_o = {cfg_i.osc_code, 4'(cfg_i.clk_div - 5'd1)};
      10: byte_o = OP_AREA;
      11: byte_o = (cfg_i.area_col ? 8'h1E : 8'h00) | (cfg_i.low_pwr ? 8'h05 : 8'h00);
      12: byte_o = OP_PRECH;
      13: byte_o = {cfg_i.pre_ph2, cfg_i.pre_ph1};
      14: byte_o = OP_COMPINS;
      15: byte_o = 8'h02 | {2'b00, cfg_i.com_swap, ~cfg_i.com_seq, 4'b0000};
      16: byte_o = OP_VCOMH;
      17: byte_o = cfg_i.vcomh;
      18: byte_o = OP_PUMP;
      19: byte_o = 8'h10 | {5'b0, cfg_i.pump, 2'b00};
      20: byte_o = OP_GAMMA;
      default: begin
        if (s >= SLOT_LUT0 && s < SLOT_ADDR) begin
          byte_o = lut_i[(s - SLOT_LUT0)*8 +: 8];
        end else if (s == SLOT_ADDR) begin
          byte_o = OP_ADDRMODE;
        end else if (s == SLOT_ADDR + 1) begin
          byte_o = cfg_i.page_mode ? 8'h02 : 8'h00;
        end else begin
          byte_o = OP_ON;
        end
      end
    endcase
  end
endmodule

// File: rtl/oled_init_seq.sv
module oled_init_seq #(
  parameter int CLK_HZ = 50_000_000,
  parameter int RST_US = 4,
  parameter int LUT_N  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic               rst_ctl_en_i,
  input  logic [7:0]         contrast_i,
  input  logic               seg_remap_i,
  input  logic               scan_inv_i,
  input  logic [7:0]         rows_i,
  input  logic [7:0]         row_offset_i,
  input  logic [4:0]         clk_div_i,
  input  logic [3:0]         osc_code_i,
  input  logic               area_col_i,
  input  logic               low_pwr_i,
  input  logic [3:0]         pre_ph1_i,
  input  logic [3:0]         pre_ph2_i,
  input  logic               com_seq_i,
  input  logic               com_swap_i,
  input  logic [7:0]         vcomh_i,
  input  logic               pump_i,
  input  logic               lut_en_i,
  input  logic [8*LUT_N-1:0] lut_i,
  input  logic               page_mode_i,
  output logic [7:0]         tx_data_o,
  output logic               tx_dc_o,
  output logic               tx_valid_o,
  input  logic               tx_ready_i,
  output logic               panel_rst_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               lut_warn_o
);
  import oled_init_pkg::*;

  localparam int RST_CYC = (CLK_HZ / 1_000_000) * RST_US;
  localparam int NSLOT   = SLOT_LUT0 + LUT_N + 3;
  localparam int SW      = $clog2(NSLOT);

  seq_state_e state_q;
  logic [SW-1:0] slot_q;
  logic [SW-1:0] slot_nxt;
  logic [SW-1:0] load_idx;
  logic [7:0]    load_byte;
  logic          slot_last;
  logic          slot_is_lut;
  logic          dly_clear;
  logic          dly_done;
  logic          hshake;
  panel_cfg_t    cfg;

  assign cfg = '{
    contrast:   contrast_i,
    seg_remap:  seg_remap_i,
    scan_inv:   scan_inv_i,
    rows:       rows_i,
    row_offset: row_offset_i,
    clk_div:    clk_div_i,
    osc_code:   osc_code_i,
    area_col:   area_col_i,
    low_pwr:    low_pwr_i,
    pre_ph1:    pre_ph1_i,
    pre_ph2:    pre_ph2_i,
    com_seq:    com_seq_i,
    com_swap:   com_swap_i,
    vcomh:      vcomh_i,
    pump:       pump_i,
    lut_en:     lut_en_i,
    page_mode:  page_mode_i
  };

  oled_slot_seq #(.LUT_N(LUT_N)) u_seq (
    .slot_i     (slot_q),
    .area_any_i (area_col_i | low_pwr_i),
    .lut_en_i   (lut_en_i),
    .next_o     (slot_nxt),
    .last_o     (slot_last),
    .is_lut_o   (slot_is_lut)
  );

  // Byte to load into the output register: slot 0 when a run begins
  assign load_idx = (state_q == ST_SEND) ? slot_nxt : '0;

  oled_byte_gen #(.LUT_N(LUT_N)) u_gen (
    .slot_i (load_idx),
    .cfg_i  (cfg),
    .lut_i  (lut_i),
    .byte_o (load_byte)
  );

  assign dly_clear = !((state_q == ST_RST_HI) || (state_q == ST_RST_LO)) || dly_done;

  oled_delay_cnt #(.CYC(RST_CYC)) u_dly (
    .clk     (clk),
    .rst     (rst),
    .clear   (dly_clear),
    .expired (dly_done)
  );

  assign hshake  = tx_valid_o && tx_ready_i;
  assign tx_dc_o = 1'b0;
  assign busy_o  = (state_q == ST_RST_HI) || (state_q == ST_RST_LO) || (state_q == ST_SEND);
  assign done_o  = (state_q == ST_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      slot_q      <= '0;
      tx_valid_o  <= 1'b0;
      tx_data_o   <= 8'h00;
      panel_rst_o <= 1'b0;
      lut_warn_o  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE, ST_DONE: begin
          if (start_i) begin
            lut_warn_o <= 1'b0;
            if (rst_ctl_en_i) begin
              state_q     <= ST_RST_HI;
              panel_rst_o <= 1'b1;
            end else begin
              state_q    <= ST_SEND;
              slot_q     <= '0;
              tx_valid_o <= 1'b1;
              tx_data_o  <= load_byte;
            end
          end
        end
        ST_RST_HI: begin
          if (dly_done) begin
            panel_rst_o <= 1'b0;
            state_q     <= ST_RST_LO;
          end
        end
        ST_RST_LO: begin
          if (dly_done) begin
            state_q    <= ST_SEND;
            slot_q     <= '0;
            tx_valid_o <= 1'b1;
            tx_data_o  <= load_byte;
          end
        end
        ST_SEND: begin
          if (hshake) begin
            if (slot_is_lut && lut_bad(tx_data_o)) lut_warn_o <= 1'b1;
            if (slot_last) begin
              tx_valid_o <= 1'b0;
              state_q    <= ST_DONE;
            end else begin
              slot_q    <= slot_nxt;
              tx_data_o <= load_byte;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/oled_init_seq_chk.sv
module oled_init_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       start_i,
  input logic [7:0] tx_data_o,
  input logic       tx_valid_o,
  input logic       tx_ready_i,
  input logic       panel_rst_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       lut_warn_o
);

  // R10
  hold_byte_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));

  // R2
  rst_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(panel_rst_o && tx_valid_o));

  // R9
  done_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(tx_valid_o && tx_ready_i && tx_data_o == 8'hAF));

  // R11
  start_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o && start_i && !(tx_valid_o && tx_ready_i && tx_data_o == 8'hAF) |=> busy_o);

  // R8
  warn_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lut_warn_o) |-> $past(tx_valid_o && tx_ready_i));

endmodule

bind oled_init_seq oled_init_seq_chk chk_i (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .tx_data_o   (tx_data_o),
  .tx_valid_o  (tx_valid_o),
  .tx_ready_i  (tx_ready_i),
  .panel_rst_o (panel_rst_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .lut_warn_o  (lut_warn_o)
);

// File: tb/oled_init_seq_tb.sv
module oled_init_seq_tb_top;
  localparam int RC = 200; // 4 us at 20 ns per cycle

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic ren = 1'b0;
  logic [7:0] contrast = 8'h7F;
  logic seg = 1'b1, inv = 1'b0;
  logic [7:0] rows = 8'd16, roff = 8'd0;
  logic [4:0] cdiv = 5'd1;
  logic [3:0] osc = 4'd8;
  logic area = 1'b0, lowp = 1'b0;
  logic [3:0] p1 = 4'd2, p2 = 4'd2;
  logic cseq = 1'b0, cswap = 1'b0;
  logic [7:0] vcomh = 8'h20;
  logic pump = 1'b1, lut_en = 1'b0;
  logic [31:0] lut = 32'h0;
  logic page = 1'b0;
  logic ready = 1'b1;
  int   rmode = 0;
  logic [15:0] lfsr = 16'hACE1;

  logic [7:0] tx_data;
  logic tx_dc, tx_valid, prst, busy, done, warn;

  oled_init_seq dut_i (
    .clk(clk), .rst(rst), .start_i(start), .rst_ctl_en_i(ren),
    .contrast_i(contrast), .seg_remap_i(seg), .scan_inv_i(inv),
    .rows_i(rows), .row_offset_i(roff), .clk_div_i(cdiv), .osc_code_i(osc),
    .area_col_i(area), .low_pwr_i(lowp), .pre_ph1_i(p1), .pre_ph2_i(p2),
    .com_seq_i(cseq), .com_swap_i(cswap), .vcomh_i(vcomh), .pump_i(pump),
    .lut_en_i(lut_en), .lut_i(lut), .page_mode_i(page),
    .tx_data_o(tx_data), .tx_dc_o(tx_dc), .tx_valid_o(tx_valid),
    .tx_ready_i(ready), .panel_rst_o(prst), .busy_o(busy), .done_o(done),
    .lut_warn_o(warn)
  );

  always #10 clk = ~clk;

  int nvec = 0;
  int nfail = 0;

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model
  logic [7:0] q_byte[$];
  string      q_tag[$];
  bit         q_warn[$];
  int m_phase = 0; // 0 idle, 1 reset high, 2 reset low, 3 sending, 4 done
  int m_cnt = 0;
  bit m_warn = 0;

  task automatic push(input int v, input string tag, input bit w);
    q_byte.push_back(8'(v));
    q_tag.push_back(tag);
    q_warn.push_back(w);
  endtask

  task automatic build();
    q_byte.delete(); q_tag.delete(); q_warn.delete();
    push(8'h81, "R3", 0); push(contrast, "R3", 0);
    push(8'hA0 + seg, "R4", 0);
    push(8'hC0 + 8 * inv, "R4", 0);
    push(8'hA8, "R3", 0); push(rows - 1, "R4", 0);
    push(8'hD3, "R3", 0); push(roff, "R3", 0);
    push(8'hD5, "R3", 0); push(16 * osc + (cdiv - 1), "R4", 0);
    if (area || lowp) begin
      push(8'hD8, "R5", 0);
      push((area ? 8'h1E : 8'h00) | (lowp ? 8'h05 : 8'h00), "R5", 0);
    end
    push(8'hD9, "R3", 0); push(16 * p2 + p1, "R4", 0);
    push(8'hDA, "R3", 0); push(2 + (cseq ? 0 : 16) + (cswap ? 32 : 0), "R6", 0);
    push(8'hDB, "R3", 0); push(vcomh, "R3", 0);
    push(8'h8D, "R3", 0); push(16 + (pump ? 4 : 0), "R6", 0);
    if (lut_en) begin
      push(8'h91, "R7", 0);
      for (int i = 0; i < 4; i++) begin
        int v;
        v = int'(lut[i*8 +: 8]);
        push(v, "R7", (v < 31) || (v > 63));
      end
    end
    push(8'h20, "R9", 0); push(page ? 2 : 0, "R9", 0);
    push(8'hAF, "R9", 0);
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_cnt = 0; m_warn = 0;
      q_byte.delete(); q_tag.delete(); q_warn.delete();
    end else begin
      case (m_phase)
        0, 4: if (start) begin
          build();
          m_warn = 0;
          if (ren) begin m_phase = 1; m_cnt = 0; end
          else m_phase = 3;
        end
        1: begin m_cnt++; if (m_cnt == RC) begin m_phase = 2; m_cnt = 0; end end
        2: begin m_cnt++; if (m_cnt == RC) begin m_phase = 3; m_cnt = 0; end end
        3: if (ready) begin
          if (q_warn[0]) m_warn = 1;
          void'(q_byte.pop_front()); void'(q_tag.pop_front()); void'(q_warn.pop_front());
          if (q_byte.size() == 0) m_phase = 4;
        end
        default: m_phase = 0;
      endcase
    end
  end

  // Compare every clock, then drive ready
  always @(negedge clk) begin
    if (!rst) begin
      chk(8'(prst), 8'(m_phase == 1), "R2");
      chk(8'(tx_valid), 8'(m_phase == 3), "R10");
      if (m_phase == 3) chk(tx_data, q_byte[0], q_tag[0]);
      chk(8'(tx_dc), 8'h00, "R3");
      chk(8'(done), 8'(m_phase == 4), "R9");
      chk(8'(busy), 8'(m_phase >= 1 && m_phase <= 3), "R11");
      chk(8'(warn), 8'(m_warn), "R8");
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    ready = (rmode == 0) ? 1'b1 : (lfsr[0] | lfsr[3]);
  end

  task automatic run_seq(input bit poke);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int c = 0; c < 5000 && m_phase != 4; c++) begin
      if (poke && (c % 37 == 5) && (m_phase == 1 || m_phase == 2 ||
          (m_phase == 3 && q_byte.size() > 1)))
        start = 1'b1; // R11: ignored while busy
      else
        start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    chk(8'(done), 8'h01, "R9");
    chk(8'(warn), 8'(m_warn), "R8");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(8'(prst), 8'h00, "R1");
    chk(8'(tx_valid), 8'h00, "R1");
    chk(8'(done), 8'h00, "R1");
    chk(8'(busy), 8'h00, "R1");
    chk(8'(warn), 8'h00, "R1");

    // Run A: reset pulse, defaults, no optional steps, ready always
    ren = 1'b1; rmode = 0;
    run_seq(1'b0);

    // Run B: no reset pulse, area colour, table with bad entries, backpressure
    ren = 1'b0; area = 1'b1; lowp = 1'b0; lut_en = 1'b1;
    lut = {8'd64, 8'd63, 8'd40, 8'd20};
    seg = 1'b0; inv = 1'b1; rows = 8'd64; roff = 8'd5; cdiv = 5'd16; osc = 4'hF;
    p1 = 4'd1; p2 = 4'd15; cseq = 1'b1; cswap = 1'b1; pump = 1'b0; page = 1'b1;
    vcomh = 8'h34; contrast = 8'hC3; rmode = 1;
    run_seq(1'b1);
    chk(8'(warn), 8'h01, "R8");

    // Run C: restart from done, low power only, in-range table clears warning
    area = 1'b0; lowp = 1'b1; lut = {8'd63, 8'd50, 8'd45, 8'd31};
    cseq = 1'b0; cswap = 1'b1; page = 1'b0; pump = 1'b1;
    run_seq(1'b1);
    chk(8'(warn), 8'h00, "R8");

    // Run D: both area flags, reset pulse, pokes during reset phases
    ren = 1'b1; area = 1'b1; lowp = 1'b1; lut_en = 1'b0; cdiv = 5'd2; osc = 4'd12;
    run_seq(1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule